// File: doc/BRIEF.md
# Double-Buffered Transmit Commit Controller

This block holds one transmit message in two physical storage banks. One bank is the commit side, which the host fills and marks as committed. The other bank is the transmit side, which the transmit engine reads while it sends a frame. The block never copies payload between the banks. When a transfer is due, it flips a one-bit bank selector, so the two banks trade roles. It then updates the per-side commit flag, the data-valid flag and a sticky interrupt flag.

The host controls the buffer with four commands: enable, disable, lock and unlock. It may write payload words and the commit bit only while the buffer is disabled or locked. The transmit engine signals each slot boundary and each request to send. The block answers a send request with a start strobe, and the engine ends the frame with a done pulse.

A mode input selects one of two commit policies. In streaming mode, a committed message waits until the transmit side has been sent at least once. In immediate mode, the swap happens at the next slot boundary whether or not the transmit side has been sent.

Top module: `txbuf_commit_ctrl`

## Requirements
- R1: After reset the buffer is disabled and unlocked, bank 0 is the commit side, and the commit, data-valid, interrupt and transfer indications all read 0.
- R2: Payload writes and commit-bit writes take effect only when the buffer is disabled (locked or not) or enabled and locked. In the enabled, unlocked state they are ignored, and both the readback and the commit bit keep their old values.
- R3: `host_cmd` takes these codes: 1 enable, 2 disable, 3 lock, 4 unlock, 0 no operation. The result shows on `st_enabled` and `st_locked` one cycle after the command.
- R4: With `cfg_immediate` = 0, a swap starts on `slot_start` only when all of these hold: the buffer is enabled and unlocked, the commit-side commit bit is 1, no frame is in flight, and the transmit side is either uncommitted or already sent (`st_tx_dval` = 1).
- R5: With `cfg_immediate` = 1, a committed commit side swaps at `slot_start` even if the transmit-side data has not been sent.
- R6: A swap exchanges the bank roles. Afterwards `host_rd_data` returns the former transmit-side words and `tx_rd_data` returns the words just committed.
- R7: After a swap, the commit-side commit bit is 0, the interrupt flag is 1, the transmit-side commit bit is 1 and the transmit-side data-valid bit is 0.
- R8: The transfer state (`st_xfer`) lasts exactly one cycle. It starts one cycle after the trigger, and the swap completes at its end. Host writes and commands that arrive in that cycle are rejected.
- R9: When `tx_req` and `slot_start` arrive in the same cycle and a transmission can start, the transmission wins and no swap starts.
- R10: `tx_start` is high in the same cycle as `tx_req` when the buffer is enabled and unlocked, the transmit side is committed, no frame is in flight and no transfer is running. A frame stays in flight until `tx_done`, and `tx_done` sets the transmit-side data-valid bit.
- R11: The interrupt flag is sticky and clears only when `host_irq_clr` is 1. A swap completing in the same cycle as the clear wins, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_immediate | input | 1 | 0 streaming policy, 1 immediate policy |
| host_cmd | input | 3 | Host command code |
| host_wr_en | input | 1 | Write a commit-side payload word |
| host_wr_addr | input | AW | Payload word index for writes |
| host_wr_data | input | W | Payload word to write |
| host_cmt_wr | input | 1 | Write the commit-side commit bit |
| host_cmt_val | input | 1 | Value for the commit bit |
| host_irq_clr | input | 1 | Write-one-to-clear of the interrupt flag |
| host_rd_addr | input | AW | Commit-side readback word index |
| host_rd_data | output | W | Commit-side word at `host_rd_addr` |
| slot_start | input | 1 | Slot boundary pulse from the transmit engine |
| tx_req | input | 1 | Transmit engine asks to send this buffer |
| tx_done | input | 1 | One-cycle pulse at the end of a sent frame |
| tx_rd_addr | input | AW | Transmit-side word index |
| tx_rd_data | output | W | Transmit-side word at `tx_rd_addr` |
| tx_start | output | 1 | Transmission accepted this cycle |
| st_enabled | output | 1 | Buffer enabled status |
| st_locked | output | 1 | Buffer locked status |
| st_xfer | output | 1 | Transfer state is active |
| st_commit_cmt | output | 1 | Commit-side commit bit |
| st_tx_cmt | output | 1 | Transmit-side commit bit |
| st_tx_dval | output | 1 | Transmit side sent at least once |
| st_irq | output | 1 | Sticky interrupt flag |

## Verification
The two data readback ports and `tx_start` are combinational. The bench drives their inputs shortly after a falling edge and checks them before the next rising edge. Commands, commit writes and `tx_done` each show on the status outputs one rising edge later. For a swap, the bench sees `st_xfer` high after the first rising edge that follows `slot_start`. The swapped payload and the updated flags appear after the second rising edge. Every check is made at the falling edge that follows the edge on which its result is due. Checks that a swap did not happen also look one more edge ahead, so a late transfer state would be caught.

// File: rtl/txc_pkg.sv
`timescale 1ns/1ps
package txc_pkg;

  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_ENABLE  = 3'd1,
    CMD_DISABLE = 3'd2,
    CMD_LOCK    = 3'd3,
    CMD_UNLOCK  = 3'd4
  } host_cmd_e;

  // Host may touch payload and commit bit: disabled (any lock) or locked.
  function automatic logic host_may_write(input logic en, input logic lck);
    return !en || lck;
  endfunction

  // Controller owns the buffer: enabled and not locked.
  function automatic logic ctrl_owns(input logic en, input logic lck);
    return en && !lck;
  endfunction

  // Policy test for the transmit side holding data.
  function automatic logic policy_allows_swap(input logic immediate,
                                              input logic tx_cmt,
                                              input logic tx_dval);
    return immediate || !tx_cmt || tx_dval;
  endfunction

endpackage

// File: rtl/txc_bank.sv
`timescale 1ns/1ps
module txc_bank #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  parameter int AW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/txc_ctrl.sv
`timescale 1ns/1ps
module txc_ctrl
  import txc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cmd,
  input  logic       xfer_start,
  input  logic       tx_go,
  input  logic       tx_done,
  output logic       enabled,
  output logic       locked,
  output logic       xfer,
  output logic       busy
);

  host_cmd_e cmd_e;
  assign cmd_e = host_cmd_e'(cmd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled <= 1'b0;
      locked  <= 1'b0;
      xfer    <= 1'b0;
      busy    <= 1'b0;
    end else begin
      xfer <= xfer_start;
      if (!xfer) begin
        case (cmd_e)
          CMD_ENABLE:  enabled <= 1'b1;
          CMD_DISABLE: enabled <= 1'b0;
          CMD_LOCK:    locked  <= 1'b1;
          CMD_UNLOCK:  locked  <= 1'b0;
          default:     ;
        endcase
      end
      if (tx_go)             busy <= 1'b1;
      else if (tx_done)      busy <= 1'b0;
    end
  end

endmodule

// File: rtl/txbuf_commit_ctrl.sv
`timescale 1ns/1ps
module txbuf_commit_ctrl
  import txc_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_immediate,
  input  logic [2:0]    host_cmd,
  input  logic          host_wr_en,
  input  logic [AW-1:0] host_wr_addr,
  input  logic [W-1:0]  host_wr_data,
  input  logic          host_cmt_wr,
  input  logic          host_cmt_val,
  input  logic          host_irq_clr,
  input  logic [AW-1:0] host_rd_addr,
  output logic [W-1:0]  host_rd_data,
  input  logic          slot_start,
  input  logic          tx_req,
  input  logic          tx_done,
  input  logic [AW-1:0] tx_rd_addr,
  output logic [W-1:0]  tx_rd_data,
  output logic          tx_start,
  output logic          st_enabled,
  output logic          st_locked,
  output logic          st_xfer,
  output logic          st_commit_cmt,
  output logic          st_tx_cmt,
  output logic          st_tx_dval,
  output logic          st_irq
);

  localparam int NBANK = 2;

  // Named internal events
  logic       enabled, locked, xfer, busy;
  logic       sel;          // bank index of the commit side
  logic       txb;          // bank index of the transmit side
  logic [1:0] cmt, dval;
  logic       irq;
  logic       wr_ok, owns, tx_go, xfer_start;

  assign txb   = ~sel;
  assign owns  = ctrl_owns(enabled, locked);
  assign wr_ok = host_may_write(enabled, locked) && !xfer;
  assign tx_go = tx_req && owns && !xfer && !busy && cmt[txb];
  assign xfer_start = slot_start && !tx_go && owns && !xfer && !busy &&
                      cmt[sel] && policy_allows_swap(cfg_immediate, cmt[txb], dval[txb]);

  txc_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (host_cmd),
    .xfer_start (xfer_start),
    .tx_go      (tx_go),
    .tx_done    (tx_done),
    .enabled    (enabled),
    .locked     (locked),
    .xfer       (xfer),
    .busy       (busy)
  );

  logic [W-1:0] rd_host [NBANK];
  logic [W-1:0] rd_tx   [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    txc_bank #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (host_wr_en && wr_ok && (sel == b[0])),
      .waddr   (host_wr_addr),
      .wdata   (host_wr_data),
      .raddr_a (host_rd_addr),
      .rdata_a (rd_host[b]),
      .raddr_b (tx_rd_addr),
      .rdata_b (rd_tx[b])
    );
  end

  assign host_rd_data = rd_host[sel];
  assign tx_rd_data   = rd_tx[txb];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel  <= 1'b0;
      cmt  <= '0;
      dval <= '0;
      irq  <= 1'b0;
    end else if (xfer) begin
      // Transfer end: roles swap, flags follow the new roles.
      sel       <= ~sel;
      cmt[txb]  <= 1'b0;
      dval[txb] <= 1'b0;
      cmt[sel]  <= 1'b1;
      dval[sel] <= 1'b0;
      irq       <= 1'b1;
    end else begin
      if (host_cmt_wr && wr_ok) cmt[sel] <= host_cmt_val;
      if (tx_done && busy)      dval[txb] <= 1'b1;
      if (host_irq_clr)         irq <= 1'b0;
    end
  end

  assign tx_start      = tx_go;
  assign st_enabled    = enabled;
  assign st_locked     = locked;
  assign st_xfer       = xfer;
  assign st_commit_cmt = cmt[sel];
  assign st_tx_cmt     = cmt[txb];
  assign st_tx_dval    = dval[txb];
  assign st_irq        = irq;

endmodule

// File: rtl/txc_sva.sv
`timescale 1ns/1ps
module txc_sva (
  input logic clk,
  input logic rst_n,
  input logic cfg_immediate,
  input logic host_cmt_wr,
  input logic host_irq_clr,
  input logic xfer_start,
  input logic xfer,
  input logic sel,
  input logic tx_start,
  input logic st_enabled,
  input logic st_locked,
  input logic st_commit_cmt,
  input logic st_tx_cmt,
  input logic st_tx_dval,
  input logic st_irq
);

  AST_XFER_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> !xfer);                                                       // R8
  AST_XFER_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> xfer);                                                  // R8
  AST_SEL_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (sel != $past(sel)));                                         // R6
  AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(sel));                                               // R6
  AST_SWAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (st_irq && !st_commit_cmt && st_tx_cmt && !st_tx_dval));      // R7
  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !cfg_immediate) |-> (!st_tx_cmt || st_tx_dval));        // R4
  AST_TX_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !xfer);                                                   // R9
  AST_CMT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_enabled && !st_locked && !xfer && host_cmt_wr) |=>
      (st_commit_cmt == $past(st_commit_cmt)));                            // R2
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_irq && !host_irq_clr) |=> st_irq);                                 // R11

endmodule

bind txbuf_commit_ctrl txc_sva u_txc_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_immediate (cfg_immediate),
  .host_cmt_wr   (host_cmt_wr),
  .host_irq_clr  (host_irq_clr),
  .xfer_start    (xfer_start),
  .xfer          (xfer),
  .sel           (sel),
  .tx_start      (tx_start),
  .st_enabled    (st_enabled),
  .st_locked     (st_locked),
  .st_commit_cmt (st_commit_cmt),
  .st_tx_cmt     (st_tx_cmt),
  .st_tx_dval    (st_tx_dval),
  .st_irq        (st_irq)
);

// File: tb/txbuf_commit_ctrl_bench.sv
`timescale 1ns/1ps
module txbuf_commit_ctrl_bench;

  localparam int W = 16;
  localparam int DEPTH = 4;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_immediate = 1'b0;
  logic [2:0]    host_cmd = '0;
  logic          host_wr_en = 1'b0;
  logic [AW-1:0] host_wr_addr = '0;
  logic [W-1:0]  host_wr_data = '0;
  logic          host_cmt_wr = 1'b0;
  logic          host_cmt_val = 1'b0;
  logic          host_irq_clr = 1'b0;
  logic [AW-1:0] host_rd_addr = '0;
  logic [W-1:0]  host_rd_data;
  logic          slot_start = 1'b0;
  logic          tx_req = 1'b0;
  logic          tx_done = 1'b0;
  logic [AW-1:0] tx_rd_addr = '0;
  logic [W-1:0]  tx_rd_data;
  logic          tx_start, st_enabled, st_locked, st_xfer;
  logic          st_commit_cmt, st_tx_cmt, st_tx_dval, st_irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;  // 50 MHz

  txbuf_commit_ctrl #(.W(W), .DEPTH(DEPTH)) u_txbuf_commit_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_immediate(cfg_immediate), .host_cmd(host_cmd),
    .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
    .host_cmt_wr(host_cmt_wr), .host_cmt_val(host_cmt_val), .host_irq_clr(host_irq_clr),
    .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data), .slot_start(slot_start),
    .tx_req(tx_req), .tx_done(tx_done), .tx_rd_addr(tx_rd_addr), .tx_rd_data(tx_rd_data),
    .tx_start(tx_start), .st_enabled(st_enabled), .st_locked(st_locked), .st_xfer(st_xfer),
    .st_commit_cmt(st_commit_cmt), .st_tx_cmt(st_tx_cmt), .st_tx_dval(st_tx_dval),
    .st_irq(st_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmd(input logic [2:0] c);
    host_cmd = c; tick(); host_cmd = '0;
  endtask

  task automatic wr_word(input int a, input logic [W-1:0] d);
    host_wr_en = 1'b1; host_wr_addr = AW'(a); host_wr_data = d;
    tick(); host_wr_en = 1'b0;
  endtask

  task automatic wr_cmt(input logic v);
    host_cmt_wr = 1'b1; host_cmt_val = v; tick(); host_cmt_wr = 1'b0;
  endtask

  task automatic load_commit(input logic [W-1:0] base);
    cmd(3'd3);
    for (int i = 0; i < DEPTH; i++) wr_word(i, base + W'(i));
    wr_cmt(1'b1);
    cmd(3'd4);
  endtask

  task automatic check_tx_words(input string req, input logic [W-1:0] base);
    for (int i = 0; i < DEPTH; i++) begin
      tx_rd_addr = AW'(i); #1;
      check(req, {16'h0, tx_rd_data}, {16'h0, base + W'(i)});
    end
  endtask

  task automatic pulse_slot();
    slot_start = 1'b1; tick(); slot_start = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", st_enabled, 0);  check("R1", st_locked, 0);
    check("R1", st_xfer, 0);     check("R1", st_commit_cmt, 0);
    check("R1", st_tx_cmt, 0);   check("R1", st_tx_dval, 0);
    check("R1", st_irq, 0);      check("R1", tx_start, 0);
  endtask

  task automatic t_cmds();
    cmd(3'd1); check("R3", st_enabled, 1);
    cmd(3'd3); check("R3", st_locked, 1);
    cmd(3'd4); check("R3", st_locked, 0);
    cmd(3'd2); check("R3", st_enabled, 0);
  endtask

  task automatic t_write_gate();
    wr_word(0, 16'h00A1);                      // disabled: accepted
    host_rd_addr = '0; #1; check("R2", host_rd_data, 16'h00A1);
    cmd(3'd1);                                 // enabled, unlocked
    wr_word(0, 16'hBEEF); #1; check("R2", host_rd_data, 16'h00A1);
    wr_cmt(1'b1); check("R2", st_commit_cmt, 0);
    cmd(3'd3);                                 // enabled, locked
    wr_word(0, 16'h00A2); #1; check("R2", host_rd_data, 16'h00A2);
    wr_cmt(1'b1); check("R2", st_commit_cmt, 1);
    wr_cmt(1'b0); check("R2", st_commit_cmt, 0);
    cmd(3'd4);
  endtask

  task automatic t_stream_swap();
    load_commit(16'h1000);
    slot_start = 1'b1; tick(); slot_start = 1'b0;
    check("R8", st_xfer, 1);
    host_cmd = 3'd3;                           // lock during transfer
    tick(); host_cmd = '0;
    check("R8", st_xfer, 0);
    check("R8", st_locked, 0);
    check("R7", st_commit_cmt, 0); check("R7", st_irq, 1);
    check("R7", st_tx_cmt, 1);     check("R7", st_tx_dval, 0);
    check_tx_words("R6", 16'h1000);
    host_rd_addr = '0; #1; check("R6", host_rd_data, 16'h0000);
  endtask

  task automatic t_stream_hold_and_send();
    load_commit(16'h2000);
    pulse_slot(); check("R4", st_xfer, 0);
    tick();       check("R4", st_xfer, 0);
    check_tx_words("R4", 16'h1000);
    tx_req = 1'b1; #1; check("R10", tx_start, 1);
    tick(); tx_req = 1'b0;
    pulse_slot(); check("R10", st_xfer, 0);    // frame in flight blocks swap
    check("R10", st_tx_dval, 0);
    tx_done = 1'b1; tick(); tx_done = 1'b0;
    check("R10", st_tx_dval, 1);
    pulse_slot(); check("R4", st_xfer, 1);
    tick();
    check_tx_words("R6", 16'h2000);
    host_rd_addr = '0; #1; check("R6", host_rd_data, 16'h1000);
  endtask

  task automatic t_priority_and_immediate();
    cfg_immediate = 1'b1;
    load_commit(16'h3000);
    tx_req = 1'b1; slot_start = 1'b1; #1;
    check("R9", tx_start, 1);
    tick(); tx_req = 1'b0; slot_start = 1'b0;
    check("R9", st_xfer, 0);
    tick(); check("R9", st_xfer, 0);
    tx_done = 1'b1; tick(); tx_done = 1'b0;
    pulse_slot(); check("R5", st_xfer, 1);
    tick(); check_tx_words("R5", 16'h3000);
    check("R5", st_tx_dval, 0);
    load_commit(16'h4000);
    pulse_slot(); check("R5", st_xfer, 1);     // unsent data replaced
    tick(); check_tx_words("R5", 16'h4000);
    cfg_immediate = 1'b0;
  endtask

  task automatic t_irq();
    check("R11", st_irq, 1);
    tick(); tick(); check("R11", st_irq, 1);
    host_irq_clr = 1'b1; tick(); host_irq_clr = 1'b0;
    check("R11", st_irq, 0);
    // clear coinciding with transfer end: set wins
    cfg_immediate = 1'b1;
    load_commit(16'h5000);
    pulse_slot(); check("R11", st_xfer, 1);
    host_irq_clr = 1'b1; tick(); host_irq_clr = 1'b0;
    check("R11", st_irq, 1);
    cfg_immediate = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_cmds();
    t_write_gate();
    t_stream_swap();
    t_stream_hold_and_send();
    t_priority_and_immediate();
    t_irq();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule